// File: doc/BRIEF.md
# Write-Protected Translation Lookaside Buffer

This block is a small, fully associative cache of page-table entries that sits in front of a memory stage. Each cycle it can take a 32-bit virtual address and a read/write flag. In that same cycle it returns one of three results. A hit carries a 30-bit physical address. A miss exception means no valid entry holds the page. A protection exception means a write reached a page that is not writable. The hardware never walks a page table. A miss is handed to software, which services it and then installs the translation through a fill port.

The fill port carries a virtual page number, a physical page number, a valid bit and a writable bit. A fill whose page number is already resident rewrites that entry in place. Any other fill takes the slot under a round-robin replacement pointer. A flush input empties the whole buffer in a single cycle. Each entry also holds a dirty flag. A permitted write hit sets it, and every hit reports it, so software can track modified pages. Read-only entries let several address spaces share pages safely.

Every lookup falls into one of four outcome classes: IDLE (no request), MISS, PROT and HIT. The class is chosen in that priority order and drives the outputs.

Each entry is updated by exactly one of three transitions per clock edge, in this priority:
- CLEAR (flush): valid and dirty drop and the pointer returns to 0.
- INSTALL (fill): the entry is rewritten and its dirty flag cleared.
- MARK (write hit): dirty is set.

Top module: `tlb_xlate_wp`

## Requirements
- R1: After reset every entry is invalid, so every lookup with `lk_req` high reports `miss_exc`=1 until a fill installs a translation.
- R2: A lookup is a hit when `lk_vaddr[31:12]` equals the page number of a valid entry and the access is either a read (`lk_write`=0) or a write to a writable entry. A hit sets `hit`=1 in the same cycle and drives `paddr` = {entry physical page number, `lk_vaddr[11:0]`}.
- R3: A lookup whose page number matches no valid entry sets `miss_exc`=1 with `hit`=0, `paddr`=0 and `lk_dirty`=0, and it changes no entry.
- R4: A write (`lk_write`=1) that matches a valid entry whose writable bit is 0 sets `prot_exc`=1 with `hit`=0 and `paddr`=0. A read of the same entry still hits.
- R5: At most one of `hit`, `miss_exc` and `prot_exc` is 1 in any cycle. All three, `paddr` and `lk_dirty` are 0 while `lk_req` is 0.
- R6: On a hit, `lk_dirty` reports the entry's dirty flag. A permitted write hit sets that flag from the next cycle on. Reads, protection exceptions and misses leave it unchanged, and any fill of the entry clears it.
- R7: A fill (`fill_en`=1, `fill_valid`=1) of a page number not resident in the buffer writes the slot under the replacement pointer, and the pointer then steps 0,1,...,7,0. The ninth such fill after reset or flush therefore evicts the first.
- R8: A fill whose page number matches a valid entry rewrites that entry (page number, physical page, valid, writable, dirty cleared) and does not move the replacement pointer.
- R9: `flush`=1 invalidates all entries and resets the replacement pointer to slot 0 at the next edge. A fill in the same cycle is discarded, and every lookup in the following cycle misses.
- R10: A fill with `fill_valid`=0 invalidates a matching resident entry. If no entry matches, it changes nothing, including the replacement pointer.
- R11: A fill takes effect at the clock edge. A lookup in the same cycle as the fill sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| hit | output | 1 | Translation found and access permitted |
| paddr | output | 30 | Physical address on a hit, else 0 |
| lk_dirty | output | 1 | Dirty flag of the hit entry, else 0 |
| miss_exc | output | 1 | No valid translation: software must fill |
| prot_exc | output | 1 | Write to a read-only page |
| fill_en | input | 1 | Install request from software |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 18 | Physical page number to install |
| fill_valid | input | 1 | Valid bit of the installed entry |
| fill_writable | input | 1 | Write permission of the installed entry |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench keeps an eight-slot model of the buffer and its pointer, and predicts every cycle's outputs from it. It sweeps every resident page with low, high and middle offsets, for both reads and writes, and it uses the page numbers 0x00000 and 0xFFFFF to expose bit-slicing mistakes. The corner cases it targets are these:
- Eviction order after eight fills. A pointer that advanced on a refill or on an unmatched invalid fill would evict the wrong page.
- A refill of a resident page. This must not create a duplicate, and a design that duplicated would report stale physical pages.
- A write to a read-only page. A design that marked it dirty or let the hit through would leak writes.
- A flush in the same cycle as a fill. A design where the fill survived would hit one cycle later.
- A lookup in the same cycle as a fill. A design with a bypass would hit one cycle early.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Outcome class of one lookup cycle, in decreasing priority.
    typedef enum logic [1:0] {
        RES_IDLE = 2'd0,
        RES_MISS = 2'd1,
        RES_PROT = 2'd2,
        RES_HIT  = 2'd3
    } lk_res_e;

    // Update applied to one entry at a clock edge.
    typedef enum logic [1:0] {
        UPD_KEEP    = 2'd0,
        UPD_CLEAR   = 2'd1,
        UPD_INSTALL = 2'd2,
        UPD_MARK    = 2'd3
    } ent_upd_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N     = 8,
    parameter int KEY_W = 20,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][KEY_W-1:0] tags,
    input  logic [KEY_W-1:0]        key,
    output logic                    any,
    output logic [IDX_W-1:0]        idx
);

    logic [N-1:0] vec;

    // One comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign vec[g] = valid[g] && (tags[g] == key);
    end

    // Fills never create duplicates, so vec is one-hot or empty.
    // An OR-encoder is therefore enough.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (flush) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 18,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [VPN_W-1:0]        wr_vpn,
    input  logic [PPN_W-1:0]        wr_ppn,
    input  logic                    wr_valid,
    input  logic                    wr_writable,
    input  logic                    mark_en,
    input  logic [IDX_W-1:0]        mark_idx,
    output logic [N-1:0]            e_valid,
    output logic [N-1:0]            e_writable,
    output logic [N-1:0]            e_dirty,
    output logic [N-1:0][VPN_W-1:0] e_tag,
    output logic [N-1:0][PPN_W-1:0] e_ppn
);

    for (genvar g = 0; g < N; g++) begin : g_ent
        ent_upd_e upd;

        // Per-entry priority: CLEAR, then INSTALL, then MARK.
        always_comb begin
            if (flush)
                upd = UPD_CLEAR;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                upd = UPD_INSTALL;
            else if (mark_en && (mark_idx == IDX_W'(g)))
                upd = UPD_MARK;
            else
                upd = UPD_KEEP;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                e_valid[g]    <= 1'b0;
                e_writable[g] <= 1'b0;
                e_dirty[g]    <= 1'b0;
                e_tag[g]      <= '0;
                e_ppn[g]      <= '0;
            end else begin
                unique case (upd)
                    UPD_CLEAR: begin
                        e_valid[g] <= 1'b0;
                        e_dirty[g] <= 1'b0;
                    end
                    UPD_INSTALL: begin
                        e_valid[g]    <= wr_valid;
                        e_writable[g] <= wr_writable;
                        e_dirty[g]    <= 1'b0;
                        e_tag[g]      <= wr_vpn;
                        e_ppn[g]      <= wr_ppn;
                    end
                    UPD_MARK: begin
                        e_dirty[g] <= 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/tlb_xlate_wp.sv
module tlb_xlate_wp
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 32,
    parameter int PA_W    = 30,
    parameter int OFF_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_req,
    input  logic [VA_W-1:0]       lk_vaddr,
    input  logic                  lk_write,
    output logic                  hit,
    output logic [PA_W-1:0]       paddr,
    output logic                  lk_dirty,
    output logic                  miss_exc,
    output logic                  prot_exc,
    input  logic                  fill_en,
    input  logic [VA_W-OFF_W-1:0] fill_vpn,
    input  logic [PA_W-OFF_W-1:0] fill_ppn,
    input  logic                  fill_valid,
    input  logic                  fill_writable,
    input  logic                  flush
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]            e_valid;
    logic [ENTRIES-1:0]            e_writable;
    logic [ENTRIES-1:0]            e_dirty;
    logic [ENTRIES-1:0][VPN_W-1:0] e_tag;
    logic [ENTRIES-1:0][PPN_W-1:0] e_ppn;

    logic             lk_any;
    logic [IDX_W-1:0] lk_idx;
    logic             fm_any;
    logic [IDX_W-1:0] fm_idx;
    logic [IDX_W-1:0] rr_ptr;

    lk_res_e          res;
    logic             install;
    logic [IDX_W-1:0] inst_idx;
    logic             rr_step;
    logic             mark_en;

    // Lookup-side associative search.
    tlb_match #(.N(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
        .valid (e_valid),
        .tags  (e_tag),
        .key   (lk_vaddr[VA_W-1:OFF_W]),
        .any   (lk_any),
        .idx   (lk_idx)
    );

    // Fill-side search, so that refills land on the resident copy.
    tlb_match #(.N(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_fill_match (
        .valid (e_valid),
        .tags  (e_tag),
        .key   (fill_vpn),
        .any   (fm_any),
        .idx   (fm_idx)
    );

    // Outcome class selection.
    always_comb begin
        if (!lk_req)
            res = RES_IDLE;
        else if (!lk_any)
            res = RES_MISS;
        else if (lk_write && !e_writable[lk_idx])
            res = RES_PROT;
        else
            res = RES_HIT;
    end

    // Output decode per outcome class.
    always_comb begin
        hit      = 1'b0;
        miss_exc = 1'b0;
        prot_exc = 1'b0;
        paddr    = '0;
        lk_dirty = 1'b0;
        unique case (res)
            RES_IDLE: begin
            end
            RES_MISS: miss_exc = 1'b1;
            RES_PROT: prot_exc = 1'b1;
            RES_HIT: begin
                hit      = 1'b1;
                paddr    = {e_ppn[lk_idx], lk_vaddr[OFF_W-1:0]};
                lk_dirty = e_dirty[lk_idx];
            end
            default: begin
            end
        endcase
    end

    // Fill placement: the resident copy if one exists, otherwise the victim.
    always_comb begin
        install  = fill_en && (fm_any || fill_valid);
        inst_idx = fm_any ? fm_idx : rr_ptr;
        rr_step  = install && !fm_any && !flush;
        mark_en  = (res == RES_HIT) && lk_write;
    end

    tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .advance (rr_step),
        .ptr     (rr_ptr)
    );

    tlb_store #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .wr_en       (install),
        .wr_idx      (inst_idx),
        .wr_vpn      (fill_vpn),
        .wr_ppn      (fill_ppn),
        .wr_valid    (fill_valid),
        .wr_writable (fill_writable),
        .mark_en     (mark_en),
        .mark_idx    (lk_idx),
        .e_valid     (e_valid),
        .e_writable  (e_writable),
        .e_dirty     (e_dirty),
        .e_tag       (e_tag),
        .e_ppn       (e_ppn)
    );

endmodule

// File: rtl/tlb_xlate_wp_chk.sv
module tlb_xlate_wp_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 30,
    parameter int OFF_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_req,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            lk_write,
    input logic            hit,
    input logic [PA_W-1:0] paddr,
    input logic            lk_dirty,
    input logic            miss_exc,
    input logic            prot_exc,
    input logic            fill_en,
    input logic            flush
);

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit, miss_exc, prot_exc})); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> (!hit && !miss_exc && !prot_exc && paddr == '0 && !lk_dirty)); // R5

    AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0])); // R2

    AST_MISS_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        miss_exc |-> (paddr == '0 && !lk_dirty)); // R3

    AST_PROT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        prot_exc |-> (lk_write && paddr == '0)); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!hit && !prot_exc)); // R9

    AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && lk_write && !fill_en && !flush) ##1
        (hit && lk_vaddr[VA_W-1:OFF_W] == $past(lk_vaddr[VA_W-1:OFF_W]))
        |-> lk_dirty); // R6

endmodule

bind tlb_xlate_wp tlb_xlate_wp_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_req   (lk_req),
    .lk_vaddr (lk_vaddr),
    .lk_write (lk_write),
    .hit      (hit),
    .paddr    (paddr),
    .lk_dirty (lk_dirty),
    .miss_exc (miss_exc),
    .prot_exc (prot_exc),
    .fill_en  (fill_en),
    .flush    (flush)
);

// File: tb/tlb_xlate_wp_test.sv
module tlb_xlate_wp_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        hit;
    logic [29:0] paddr;
    logic        lk_dirty;
    logic        miss_exc;
    logic        prot_exc;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [17:0] fill_ppn = '0;
    logic        fill_valid = 1'b0;
    logic        fill_writable = 1'b0;
    logic        flush = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model of the eight slots and the replacement pointer.
    logic [19:0] m_vpn [8];
    logic [17:0] m_ppn [8];
    bit          m_val [8];
    bit          m_wr  [8];
    bit          m_dty [8];
    int          m_ptr;

    always #10 clk = ~clk;  // 50 MHz

    tlb_xlate_wp uut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .hit(hit), .paddr(paddr), .lk_dirty(lk_dirty),
        .miss_exc(miss_exc), .prot_exc(prot_exc), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_valid(fill_valid),
        .fill_writable(fill_writable), .flush(flush)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [19:0] vpn_of(int k);
        if (k == 0) return 20'h00000;
        if (k == 7) return 20'hFFFFF;
        return 20'((k * 32'h2493) + 32'h10);
    endfunction

    function automatic logic [17:0] ppn_of(int k);
        if (k == 7) return 18'h3FFFF;
        return 18'((k * 32'h5A5) + 32'h3);
    endfunction

    // One clock cycle with optional fill, lookup and flush; predicts and checks.
    task automatic cyc(string tag, bit f, logic [19:0] fv, logic [17:0] fp, bit fval,
                       bit fw, bit l, logic [31:0] va, bit wr, bit fl);
        int mi;
        int fj;
        bit e_hit, e_miss, e_prot, e_dty;
        logic [29:0] e_pa;
        @(negedge clk);
        fill_en = f; fill_vpn = fv; fill_ppn = fp; fill_valid = fval; fill_writable = fw;
        lk_req = l; lk_vaddr = va; lk_write = wr; flush = fl;
        #2;
        mi = -1;
        for (int i = 0; i < 8; i++) if (m_val[i] && m_vpn[i] == va[31:12]) mi = i;
        e_hit = 0; e_miss = 0; e_prot = 0; e_dty = 0; e_pa = '0;
        if (l) begin
            if (mi < 0) e_miss = 1;
            else if (wr && !m_wr[mi]) e_prot = 1;
            else begin
                e_hit = 1;
                e_pa = {m_ppn[mi], va[11:0]};
                e_dty = m_dty[mi];
            end
        end
        chk(tag, "hit", 32'(hit), 32'(e_hit));
        chk(tag, "miss_exc", 32'(miss_exc), 32'(e_miss));
        chk(tag, "prot_exc", 32'(prot_exc), 32'(e_prot));
        chk(tag, "paddr", 32'(paddr), 32'(e_pa));
        chk(tag, "lk_dirty", 32'(lk_dirty), 32'(e_dty));
        @(posedge clk);
        if (e_hit && wr) m_dty[mi] = 1;
        if (fl) begin
            for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_dty[i] = 0; end
            m_ptr = 0;
        end else if (f) begin
            fj = -1;
            for (int i = 0; i < 8; i++) if (m_val[i] && m_vpn[i] == fv) fj = i;
            if (fj < 0 && fval) begin
                fj = m_ptr;
                m_ptr = (m_ptr + 1) % 8;
            end
            if (fj >= 0) begin
                m_vpn[fj] = fv; m_ppn[fj] = fp; m_val[fj] = fval;
                m_wr[fj] = fw; m_dty[fj] = 0;
            end
        end
        #1;
        fill_en = 0; lk_req = 0; lk_write = 0; flush = 0;
    endtask

    task automatic look(string tag, logic [31:0] va, bit wr);
        cyc(tag, 0, '0, '0, 0, 0, 1, va, wr, 0);
    endtask

    task automatic fill(string tag, logic [19:0] v, logic [17:0] p, bit val, bit w);
        cyc(tag, 1, v, p, val, w, 0, '0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_vpn[i] = '0; m_ppn[i] = '0; m_val[i] = 0; m_wr[i] = 0; m_dty[i] = 0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset; R5: idle cycle is quiet
        for (int k = 0; k < 8; k++) look("R1", {vpn_of(k), 12'h3C5}, k[0]);
        cyc("R5", 0, '0, '0, 0, 0, 0, 32'h1234_5678, 1, 0);

        // R7: fill eight distinct pages, even k writable
        for (int k = 0; k < 8; k++) fill("R7", vpn_of(k), ppn_of(k), 1, ~k[0]);

        // R2/R3/R4/R6 sweep over all pages and offsets
        for (int k = 0; k < 8; k++) begin
            look("R2", {vpn_of(k), 12'h000}, 0);
            look("R2", {vpn_of(k), 12'hFFF}, 0);
            look("R4", {vpn_of(k), 12'h5A3}, 1);
            look("R6", {vpn_of(k), 12'h801}, 0);
            look("R6", {vpn_of(k), 12'h802}, 1);
            look("R3", {vpn_of(k) ^ 20'h40000, 12'h010}, k[0]);
        end

        // R7: ninth distinct fill evicts the first
        fill("R7", vpn_of(8), ppn_of(8), 1, 1);
        look("R7", {vpn_of(0), 12'h111}, 0);
        look("R7", {vpn_of(8), 12'h222}, 0);
        look("R7", {vpn_of(1), 12'h333}, 0);

        // R8: refill resident page in place; pointer holds
        fill("R8", vpn_of(3), 18'h2AAAA, 1, 1);
        look("R8", {vpn_of(3), 12'h444}, 0);
        look("R8", {vpn_of(3), 12'h445}, 1);
        look("R8", {vpn_of(3), 12'h446}, 0);
        fill("R8", vpn_of(9), ppn_of(9), 1, 0);
        look("R8", {vpn_of(1), 12'h555}, 0);
        look("R8", {vpn_of(2), 12'h556}, 0);
        look("R8", {vpn_of(9), 12'h557}, 1);

        // R10: invalid fills
        fill("R10", vpn_of(10), ppn_of(10), 0, 1);
        for (int k = 2; k < 10; k++) look("R10", {vpn_of(k), 12'h0A0}, 0);
        fill("R10", vpn_of(2), ppn_of(2), 0, 1);
        look("R10", {vpn_of(2), 12'h0A1}, 0);
        fill("R10", vpn_of(11), ppn_of(11), 1, 1);
        look("R10", {vpn_of(11), 12'h0A2}, 0);
        look("R10", {vpn_of(4), 12'h0A3}, 0);

        // R11: lookup concurrent with fill sees old contents
        cyc("R11", 1, vpn_of(12), ppn_of(12), 1, 1, 1, {vpn_of(12), 12'h777}, 0, 0);
        look("R11", {vpn_of(12), 12'h778}, 0);

        // R9: flush beats simultaneous fill, then everything misses
        cyc("R9", 1, vpn_of(13), ppn_of(13), 1, 1, 0, '0, 0, 1);
        for (int k = 0; k < 14; k++) look("R9", {vpn_of(k), 12'h999}, 0);
        for (int k = 14; k < 22; k++) fill("R9", vpn_of(k), ppn_of(k), 1, k[0]);
        fill("R9", vpn_of(22), ppn_of(22), 1, 1);
        look("R9", {vpn_of(14), 12'h998}, 0);
        look("R9", {vpn_of(15), 12'h997}, 0);

        // Final sweep of everything ever used
        for (int k = 0; k < 23; k++) begin
            look("R2", {vpn_of(k), 12'h6B7}, 0);
            look("R4", {vpn_of(k), 12'h6B8}, 1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule